// File: doc/BRIEF.md
# Board Test Synchronization Controller

This block sits on each board of a multi-board backplane test and keeps the board's scan operations in step with every other board during a test session. It reports its own scan-chain length, which is fixed at build time. The session master replies with the longest chain length in the system. For every pattern, the block then walks through a window of clocks. The window starts with serial shifting over the board's own chain. Idle pause clocks follow, filling the time that a longer chain on another board would still spend shifting. The window ends with one clock in which the new pattern is applied and the response is captured. All boards therefore apply and capture on the same clock, whatever the length of their own chains.

While the shifts run, the bit coming back out of the chain is folded into a 16-bit multiple-input signature register. After the last pattern, one more shift window unloads the final response. The signature is then compared on the board with an expected value that was loaded when the session started, and the board raises a pass flag. An abort input stops a session from any state.

Top module: `board_test_sync`

## Requirements
- R1: `chainLenOut` always equals the build-time chain length parameter L (default 5).
- R2: The clock after a start is accepted, a window begins. In each pattern window, `shiftEn` is high for exactly the first L clocks. A start is accepted when `startReq` is high, `abortReq` is low and `busy` is low.
- R3: In each pattern window, `pauseEn` is high for the next Lmax−L clocks, and `updCapEn` is then high for one clock. Each window is therefore Lmax+1 clocks long, and the capture falls at offset Lmax whatever the value of L.
- R4: After the last pattern window comes a flush window of Lmax clocks: L clocks of shifting, then Lmax−L clocks of pause, with no capture. `busy` stays high for exactly P×(Lmax+1)+Lmax clocks, where P is the pattern count. `done` rises on the next clock.
- R5: The signature is cleared at start. On a shift clock, and only once at least one capture has occurred in the session, the signature is updated from `scanIn` as s' = (s<<1) ^ (s[15] ? 0x1021 : 0) ^ scanIn, with `scanIn` entering bit 0. On all other clocks the signature holds.
- R6: While `done` is high, `pass` is high exactly when the final signature equals the `expSigIn` value sampled at start. `pass` holds until the next accepted start or an abort.
- R7: When `abortReq` is high, the next clock shows `busy`, `done`, `pass`, `shiftEn`, `pauseEn` and `updCapEn` all low.
- R8: After reset, all outputs except `chainLenOut` are low.
- R9: With a pattern count of 0, a session consists of the flush window alone, and `done` rises Lmax clocks after start.
- R10: Changes to `lmaxIn`, `patCountIn` and `expSigIn` after a start is accepted have no effect on the timing or on the pass result of that session.
- R11: A `startReq` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Begin a session when idle or done |
| abortReq | input | 1 | Return to idle and clear pass |
| lmaxIn | input | LEN_W | Longest chain length in the system, sampled at start |
| patCountIn | input | PAT_W | Number of patterns in the session, sampled at start |
| expSigIn | input | SIG_W | Expected signature, sampled at start |
| scanIn | input | 1 | Serial bit returning from the board's scan chain |
| chainLenOut | output | LEN_W | This board's chain length, reported to the master |
| shiftEn | output | 1 | Shift the chain this clock |
| pauseEn | output | 1 | Pause padding clock |
| updCapEn | output | 1 | Apply the pattern and capture the response this clock |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished, result valid |
| pass | output | 1 | Signature matched the expected value |

## Verification
The assertions take for granted that `lmaxIn` is never smaller than L when a start is accepted. If it were, the pause span would be negative and the window arithmetic would be meaningless. The stimulus always draws Lmax between L and L+12, and it includes the equal case, in which there are no pause clocks at all. Start and abort are driven as single-clock pulses between clock edges. Pattern counts range from zero up to five.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FLUSH, ST_DONE} tsyncState_t;

  typedef struct packed {
    logic clearSig;
    logic loadExp;
    logic compress;
    logic compare;
    logic clearPass;
  } tsyncStrobe_t;
endpackage

// File: rtl/tsync_ctrl.sv
module tsync_ctrl
  import tsync_pkg::*;
#(
  parameter int CHAIN_LEN = 5,
  parameter int LEN_W     = 8,
  parameter int PAT_W     = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             abortReq,
  input  logic [LEN_W-1:0] lmaxIn,
  input  logic [PAT_W-1:0] patCountIn,
  output tsyncStrobe_t     strobe,
  output logic             shiftEn,
  output logic             pauseEn,
  output logic             updCapEn,
  output logic             busy,
  output logic             done
);
  localparam logic [LEN_W-1:0] L_VAL   = LEN_W'(CHAIN_LEN);
  localparam logic [PAT_W-1:0] PAT_ONE = PAT_W'(1);

  tsyncState_t      state;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] lmaxQ;
  logic [PAT_W-1:0] patLeft;
  logic             seenCap;
  logic             inWin;
  logic             launch;
  logic             lastFlush;

  always_comb begin
    inWin     = (state == ST_RUN) || (state == ST_FLUSH);
    shiftEn   = inWin && (cnt < L_VAL);
    updCapEn  = (state == ST_RUN) && (cnt == lmaxQ);
    pauseEn   = inWin && !shiftEn && !updCapEn;
    lastFlush = (state == ST_FLUSH) && (cnt == lmaxQ - 1'b1);
    busy      = inWin;
    done      = (state == ST_DONE);
    launch    = ((state == ST_IDLE) || (state == ST_DONE)) && startReq && !abortReq;

    strobe.clearSig  = launch;
    strobe.loadExp   = launch;
    strobe.clearPass = launch || abortReq;
    strobe.compress  = shiftEn && seenCap && !abortReq;
    strobe.compare   = lastFlush && !abortReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      lmaxQ   <= '0;
      patLeft <= '0;
      seenCap <= 1'b0;
    end else if (abortReq) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      seenCap <= 1'b0;
    end else if (launch) begin
      state   <= (patCountIn != '0) ? ST_RUN : ST_FLUSH;
      cnt     <= '0;
      lmaxQ   <= lmaxIn;
      patLeft <= patCountIn;
      seenCap <= 1'b0;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (updCapEn) begin
            cnt     <= '0;
            seenCap <= 1'b1;
            patLeft <= patLeft - 1'b1;
            if (patLeft == PAT_ONE) state <= ST_FLUSH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FLUSH: begin
          if (lastFlush) begin
            state <= ST_DONE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_LMAX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !abortReq && !busy) |-> (lmaxIn >= L_VAL)) else $error("lmax below chain length"); // R2
  AST_SHIFT_START: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !abortReq && !busy) |=> shiftEn) else $error("no shift after start"); // R2
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({shiftEn, pauseEn, updCapEn})) else $error("phases overlap"); // R3
  AST_PAUSE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (pauseEn && !abortReq) |=> !shiftEn) else $error("shift after pause"); // R3
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> (!busy && !done)) else $error("abort not honoured"); // R7
endmodule

// File: rtl/tsync_datapath.sv
module tsync_datapath
  import tsync_pkg::*;
#(
  parameter int              SIG_W = 16,
  parameter logic [SIG_W-1:0] POLY = 16'h1021
) (
  input  logic             clk,
  input  logic             rstN,
  input  tsyncStrobe_t     strobe,
  input  logic             scanIn,
  input  logic [SIG_W-1:0] expSigIn,
  output logic             passOut
);
  logic [SIG_W-1:0] misr;
  logic [SIG_W-1:0] misrNext;
  logic [SIG_W-1:0] expQ;
  logic             passQ;

  always_comb begin
    misrNext = misr;
    if (strobe.compress)
      misrNext = {misr[SIG_W-2:0], 1'b0} ^ (misr[SIG_W-1] ? POLY : '0)
                 ^ {{(SIG_W-1){1'b0}}, scanIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      misr  <= '0;
      expQ  <= '0;
      passQ <= 1'b0;
    end else begin
      misr <= strobe.clearSig ? '0 : misrNext;
      if (strobe.loadExp) expQ <= expSigIn;
      if (strobe.clearPass)    passQ <= 1'b0;
      else if (strobe.compare) passQ <= (misrNext == expQ);
    end
  end

  assign passOut = passQ;

  AST_PASS_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearPass |=> !passQ) else $error("pass not cleared"); // R6
  AST_SIG_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearSig |=> (misr == '0)) else $error("signature not cleared"); // R5
endmodule

// File: rtl/board_test_sync.sv
module board_test_sync
  import tsync_pkg::*;
#(
  parameter int CHAIN_LEN = 5,
  parameter int LEN_W     = 8,
  parameter int PAT_W     = 6,
  parameter int SIG_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             abortReq,
  input  logic [LEN_W-1:0] lmaxIn,
  input  logic [PAT_W-1:0] patCountIn,
  input  logic [SIG_W-1:0] expSigIn,
  input  logic             scanIn,
  output logic [LEN_W-1:0] chainLenOut,
  output logic             shiftEn,
  output logic             pauseEn,
  output logic             updCapEn,
  output logic             busy,
  output logic             done,
  output logic             pass
);
  tsyncStrobe_t strobe;

  assign chainLenOut = LEN_W'(CHAIN_LEN);

  tsync_ctrl #(.CHAIN_LEN(CHAIN_LEN), .LEN_W(LEN_W), .PAT_W(PAT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .lmaxIn(lmaxIn), .patCountIn(patCountIn), .strobe(strobe),
    .shiftEn(shiftEn), .pauseEn(pauseEn), .updCapEn(updCapEn),
    .busy(busy), .done(done)
  );

  tsync_datapath #(.SIG_W(SIG_W), .POLY(SIG_W'(16'h1021))) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .scanIn(scanIn),
    .expSigIn(expSigIn), .passOut(pass)
  );

  AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> done) else $error("pass without done"); // R6
endmodule

// File: tb/board_test_sync_tb.sv
`timescale 1ns/1ps
module board_test_sync_tb;
  localparam int L = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        abortReq = 1'b0;
  logic [7:0]  lmaxIn = '0;
  logic [5:0]  patCountIn = '0;
  logic [15:0] expSigIn = '0;
  logic        scanIn = 1'b0;
  logic [7:0]  chainLenOut;
  logic        shiftEn, pauseEn, updCapEn, busy, done, pass;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  board_test_sync u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .lmaxIn(lmaxIn), .patCountIn(patCountIn), .expSigIn(expSigIn),
    .scanIn(scanIn), .chainLenOut(chainLenOut), .shiftEn(shiftEn),
    .pauseEn(pauseEn), .updCapEn(updCapEn), .busy(busy), .done(done),
    .pass(pass)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic bitAt(input int unsigned seedS, input int c);
    int unsigned h;
    h = (32'(c) * 32'h9E3779B1) ^ seedS;
    return h[13];
  endfunction

  function automatic logic [15:0] sigStep(input logic [15:0] s, input logic b);
    return {s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0) ^ {15'd0, b};
  endfunction

  // phase of cycle c: 0 shift, 1 pause, 2 capture
  function automatic int phaseAt(input int lmax, input int p, input int c);
    int w, off;
    w = c / (lmax + 1);
    if (w < p) begin
      off = c % (lmax + 1);
      if (off < L) return 0;
      if (off == lmax) return 2;
      return 1;
    end
    off = c - p * (lmax + 1);
    return (off < L) ? 0 : 1;
  endfunction

  task automatic runSession(input int lmax, input int p, input bit match,
                            input bit midChange, input bit midStart);
    int unsigned seedS;
    int total, ph;
    logic [15:0] sig;
    seedS = $urandom;
    total = p * (lmax + 1) + lmax;
    sig = '0;
    for (int c = 0; c < total; c++)
      if (phaseAt(lmax, p, c) == 0 && c >= lmax + 1) sig = sigStep(sig, bitAt(seedS, c));
    lmaxIn = 8'(lmax);
    patCountIn = 6'(p);
    expSigIn = match ? sig : (sig ^ 16'h0100);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int c = 0; c < total; c++) begin
      ph = phaseAt(lmax, p, c);
      check("R2 shiftEn", shiftEn, ph == 0);
      check("R3 pauseEn", pauseEn, ph == 1);
      check("R3 updCapEn", updCapEn, ph == 2);
      check("R4 busy", busy, 1);
      check("R4 done early", done, 0);
      scanIn = bitAt(seedS, c);
      if (midChange && c == 2) begin
        lmaxIn = 8'(lmax + 3);
        patCountIn = 6'(p + 2);
        expSigIn = ~expSigIn;   // R10 inputs move mid-session
      end
      if (midStart && c == 3) startReq = 1'b1;  // R11
      if (midStart && c == 4) startReq = 1'b0;
      @(negedge clk);
    end
    startReq = 1'b0;
    check("R4 done at end", done, 1);
    check("R4 busy at end", busy, 0);
    check(midChange ? "R10 pass latched" : (p == 0 ? "R9 pass" : "R6 pass"), pass, match);
    check("R5 no shift after end", shiftEn | pauseEn | updCapEn, 0);
    if (midStart) check("R11 ignored start", busy, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    check("R8 reset busy", busy, 0);
    check("R8 reset done/pass", done | pass, 0);
    check("R8 reset phases", shiftEn | pauseEn | updCapEn, 0);
    check("R1 chain length", chainLenOut, L);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", busy | done | pass, 0);

    runSession(L, 3, 1'b1, 1'b0, 1'b0);        // no pause clocks
    runSession(L + 7, 2, 1'b1, 1'b0, 1'b0);
    runSession(L + 4, 0, 1'b0, 1'b0, 1'b0);    // R9 flush only, sig 0 vs 0x0100
    runSession(L + 2, 0, 1'b1, 1'b0, 1'b0);    // R9 flush only matching
    runSession(L + 3, 4, 1'b0, 1'b0, 1'b0);    // mismatch R6
    runSession(L + 5, 3, 1'b1, 1'b1, 1'b0);    // R10
    runSession(L + 1, 2, 1'b1, 1'b0, 1'b1);    // R11
    for (int i = 0; i < 8; i++)
      runSession(L + int'($urandom_range(0, 12)), int'($urandom_range(0, 5)),
                 bit'($urandom_range(0, 1)), 1'b0, 1'b0);

    // R7 abort from done with pass high
    runSession(L + 2, 1, 1'b1, 1'b0, 1'b0);
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    check("R7 abort clears pass", pass, 0);
    check("R7 abort clears done", done, 0);

    // R7 abort mid-pattern
    lmaxIn = 8'(L + 3);
    patCountIn = 6'd3;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (7) @(negedge clk);
    check("R7 running before abort", busy, 1);
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    check("R7 abort busy", busy, 0);
    check("R7 abort phases", shiftEn | pauseEn | updCapEn, 0);
    check("R7 abort done/pass", done | pass, 0);
    repeat (3) @(negedge clk);
    check("R7 stays idle", busy | done, 0);
    check("R1 chain length later", chainLenOut, L);

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule